// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A load strobe captures a start address. Its two low bits seed a wrapping beat sequence, and the bits above them are held for the whole burst. An active-low advance input steps the sequence by one beat at each rising clock edge where it is low. The mode input picks the order of the beats. In interleaved order each beat XORs the start with the beat index. In linear order the beat index is added to the start, modulo four.

The block has no read/write input, so read bursts and write bursts step through the same sequence. The current address and the current beat index both come straight from registers. The mode is sampled at every edge, so the order that applies is the one selected at the most recent edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `cur_addr` and `beat` become zero.
- R2: When `load` is high at an edge, after that edge `cur_addr` equals `load_addr` and `beat` equals 0.
- R3: When `load` is high at an edge, `adv_n` has no effect: `beat` is 0 after that edge whatever the value of `adv_n`.
- R4: With `mode_ilv` = 1 at an edge, the two low bits of `cur_addr` after that edge equal start XOR `beat`, where start is the two low bits of the last loaded address.
- R5: With `mode_ilv` = 0 at an edge, the two low bits of `cur_addr` after that edge equal (start + `beat`) mod 4.
- R6: When `load` is low and `adv_n` is high at an edge, `beat` keeps its value.
- R7: When `load` is low and `adv_n` is low at an edge, `beat` steps by one. From 3 it wraps to 0, so the address returns to the first address of the burst.
- R8: The bits of `cur_addr` above bit 1 change only at an edge where `load` is high.
- R9: A change of `mode_ilv` in the middle of a burst remaps the current beat under the new order from the next edge, and `beat` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Captures `load_addr` and starts a burst |
| load_addr | input | ADDR_W | Start address of the burst |
| adv_n | input | 1 | Active-low advance to the next beat |
| mode_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| cur_addr | output | ADDR_W | Registered current beat address |
| beat | output | 2 | Registered beat index, 0 to 3 |

## Verification
Every cycle, the assertions check the following: the reset and load results, the hold and step-with-wrap rules of the beat index, the stability of the upper bits, and the order invariants. The order invariants are that low bits XOR beat stays constant in interleaved mode, and that low bits minus beat stays constant in linear mode. The invariants cannot show that the absolute addresses are right for each of the four starts, or that a mode change in mid-burst lands on the right address. The bench scenarios cover those cases by comparing against a behavioural model on every cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTERLEAVED = 1'b1} order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  adv_n,
  output beat_t beat_q,
  output beat_t beat_d
);
  // load wins over advance; counter wraps naturally at its width
  always_comb begin
    if (load)        beat_d = '0;
    else if (!adv_n) beat_d = beat_q + beat_t'(1);
    else             beat_d = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_d;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
(
  input  beat_t  start,
  input  beat_t  idx,
  input  order_e order,
  output beat_t  low
);
  beat_t lin_low;
  beat_t ilv_low;

  assign lin_low = start + idx;
  assign ilv_low = start ^ idx;
  assign low     = (order == ORD_INTERLEAVED) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv_n,
  input  logic              mode_ilv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat
);
  localparam int HI_W = ADDR_W - BEAT_W;

  beat_t           start_q, start_d;
  beat_t           beat_q, beat_d;
  beat_t           low_d;
  logic [HI_W-1:0] hi_q, hi_d;
  order_e          order;

  assign order   = mode_ilv ? ORD_INTERLEAVED : ORD_LINEAR;
  assign start_d = load ? load_addr[BEAT_W-1:0] : start_q;
  assign hi_d    = load ? load_addr[ADDR_W-1:BEAT_W] : hi_q;

  burst_beat_ctr u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .adv_n  (adv_n),
    .beat_q (beat_q),
    .beat_d (beat_d)
  );

  burst_order_map u_map (
    .start (start_d),
    .idx   (beat_d),
    .order (order),
    .low   (low_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      hi_q     <= '0;
      cur_addr <= '0;
    end else begin
      start_q  <= start_d;
      hi_q     <= hi_d;
      cur_addr <= {hi_d, low_d};
    end
  end

  assign beat = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic [ADDR_W-1:0] load_addr,
  input logic              adv_n,
  input logic              mode_ilv,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [1:0]        beat
);
  logic [1:0] low;
  logic [1:0] ilv_key;
  logic [1:0] lin_key;
  assign low     = cur_addr[1:0];
  assign ilv_key = low ^ beat;
  assign lin_key = low - beat;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && beat == 2'd0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_addr == $past(load_addr)));

  assert_load_beat_zero_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat == 2'd0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && adv_n) |=> $stable(beat));

  assert_step_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> (beat == 2'($past(beat) + 2'd1)));

  assert_upper_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur_addr[ADDR_W-1:2]));

  assert_ilv_order_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && mode_ilv && $past(mode_ilv)) |=> (ilv_key == $past(ilv_key)));

  assert_lin_order_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !mode_ilv && !$past(mode_ilv)) |=> (lin_key == $past(lin_key)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .load_addr (load_addr),
  .adv_n     (adv_n),
  .mode_ilv  (mode_ilv),
  .cur_addr  (cur_addr),
  .beat      (beat)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              load = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic              adv_n = 1'b1;
  logic              mode_ilv = 1'b1;
  logic [ADDR_W-1:0] cur_addr;
  logic [1:0]        beat;

  int checks = 0;
  int fails  = 0;

  // reference state
  int m_hi, m_start, m_beat, m_mode;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_burst_addr_seq (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr),
    .adv_n(adv_n), .mode_ilv(mode_ilv), .cur_addr(cur_addr), .beat(beat)
  );

  function automatic int exp_addr();
    int lo;
    if (m_mode != 0) lo = m_start ^ m_beat;
    else             lo = (m_start + m_beat) % 4;
    return m_hi * 4 + lo;
  endfunction

  task automatic tick(input string tag);
    int ea;
    @(posedge clk);
    if (rst) begin
      m_hi = 0; m_start = 0; m_beat = 0; m_mode = 0;
    end else begin
      if (load) begin
        m_hi = int'(load_addr[ADDR_W-1:2]);
        m_start = int'(load_addr[1:0]);
        m_beat = 0;
      end else if (!adv_n) begin
        m_beat = (m_beat + 1) % 4;
      end
      m_mode = mode_ilv ? 1 : 0;
    end
    @(negedge clk);
    ea = rst ? 0 : exp_addr();
    if (rst) ea = 0;
    checks++;
    if (int'(cur_addr) != ea || int'(beat) != m_beat) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, cur_addr, beat, ea[ADDR_W-1:0], m_beat);
    end
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input logic m,
                         input logic adv, input string tag);
    load = 1'b1; load_addr = a; mode_ilv = m; adv_n = adv;
    tick(tag);
    load = 1'b0; adv_n = 1'b1;
  endtask

  task automatic step(input logic adv, input string tag);
    adv_n = adv;
    tick(tag);
    adv_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, with load and advance active during reset
    load = 1'b1; load_addr = 20'hABCDE; adv_n = 1'b0;
    for (int i = 0; i < 3; i++) tick("R1 reset");
    load = 1'b0; adv_n = 1'b1;
    rst = 1'b0;

    // R2/R3: load with advance asserted at the same edge
    do_load(20'h12346, 1'b1, 1'b0, "R2 R3 load ignores advance");
    // R4/R7/R8: interleaved from start 2: 2,3,0,1 then wrap
    for (int i = 0; i < 4; i++) step(1'b0, "R4 R7 R8 interleaved step");
    // R6: hold
    for (int i = 0; i < 3; i++) step(1'b1, "R6 hold");

    // R5/R7: linear from start 3: 3,0,1,2 then wrap
    do_load(20'hFFFF7, 1'b0, 1'b1, "R2 linear load");
    for (int i = 0; i < 5; i++) step(1'b0, "R5 R7 linear step");

    // R9: mode change mid-burst
    do_load(20'h00031, 1'b0, 1'b1, "R2 load for mode switch");
    step(1'b0, "R5 linear beat1");
    mode_ilv = 1'b1;
    step(1'b1, "R9 remap to interleaved");
    step(1'b0, "R9 interleaved after switch");
    mode_ilv = 1'b0;
    step(1'b1, "R9 remap back to linear");

    // all starts, both orders, including reload mid-burst (R8 upper change)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        do_load(ADDR_W'(s + 4 * (37 * s + 11 * m + 5)), m[0], 1'b0, "R2 R3 sweep load");
        for (int k = 0; k < 5; k++) step(k[0], "R4 R5 R6 R7 sweep");
      end
    end

    // R1: reset in the middle of a burst
    do_load(20'h5555A, 1'b1, 1'b1, "R2 pre-reset load");
    step(1'b0, "R4 pre-reset step");
    rst = 1'b1;
    tick("R1 mid-burst reset");
    rst = 1'b0;
    step(1'b0, "R7 step after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule